// File: doc/BRIEF.md
# Receive FIFO with Trigger and Idle Flags

This block is the receive side of a UART-style serial controller. It queues received bytes in a 16-entry first-in first-out store and keeps a live count of them. The bytes come either from the line deserializer or, when loopback is selected, from the transmit path. The CPU removes bytes through a pop port. The count is the value software reads as the low receive-count field of a shared data-count register.

Two flags tell software when to read. The threshold flag sets once the count reaches a programmable trigger level. The idle flag sets when a partly filled queue has seen no new byte for two frame times. A sticky overrun flag records a byte lost to a full queue, and it stops all reception until software clears it. From these flags the block raises a receive interrupt request, a receive-error interrupt request and a one-cycle DMA request.

Software clears a flag by writing zero to its bit. The flag only falls if the condition behind it has gone away.

Top module: `rxq_flag_ctrl`

## Requirements
- R1: The queue holds up to 16 bytes and pops them in arrival order. `rx_count` reports the number stored, 0 to 16, one cycle after the push or pop.
- R2: `trig_sel` codes 0, 1, 2 and 3 give trigger levels of 1, 4, 8 and 14 bytes. When an accepted push leaves the count at or above the trigger, `full_flag` sets, `rx_irq` asserts if `rie` is high, and `dma_req` pulses for one cycle.
- R3: A push into a full queue, with no pop in the same cycle, discards the byte and sets `ovr_flag`. `err_irq` asserts if `rie` or `eie` is high.
- R4: Pushes are ignored while `rx_en` is low or `ovr_flag` is set. `ovr_flag` clears only on a flag write with bit 2 of `flag_wdata` at zero, and `err_irq` drops with it.
- R5: At a `frame_tick` cycle, `ready_flag` sets when the queue is non-empty, the count is below the trigger, and no byte was accepted in the current or previous tick interval. The same event raises `rx_irq` (when `rie` is high) and pulses `dma_req`.
- R6: After a pop, `full_flag` clears if the count is below the trigger, and `ready_flag` clears if the count is zero. `rx_irq` drops once both flags are clear.
- R7: `fifo_reset` empties the queue, clears `full_flag` and `ready_flag`, and drops `rx_irq`. It leaves `ovr_flag` as it is.
- R8: A `flag_wr` with a zero in `flag_wdata` bit 1 clears `full_flag` only when the count is below the trigger. A zero in bit 0 clears `ready_flag` only when the queue is empty.
- R9: With `loop_sel` high, bytes come from `loop_valid`/`loop_data` and the line inputs are ignored. With `loop_sel` low, the reverse holds.
- R10: A pop of an empty queue returns 0x00 on `pop_data` and changes no count or flag.
- R11: `pop_data` holds the popped byte from the cycle after `pop_req` until the next pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive enable |
| loop_sel | input | 1 | Take bytes from the loopback path |
| line_valid | input | 1 | Byte strobe from the deserializer |
| line_data | input | 8 | Byte from the deserializer |
| loop_valid | input | 1 | Byte strobe from the loopback path |
| loop_data | input | 8 | Byte from the loopback path |
| trig_sel | input | 2 | Trigger level code |
| rie | input | 1 | Receive interrupt enable |
| eie | input | 1 | Error interrupt enable |
| frame_tick | input | 1 | One-cycle strobe at each frame time |
| pop_req | input | 1 | CPU pop request |
| fifo_reset | input | 1 | Empty the queue |
| flag_wr | input | 1 | Flag write strobe |
| flag_wdata | input | 3 | Flag write data: bit 0 idle, bit 1 threshold, bit 2 overrun; a zero requests a clear |
| pop_data | output | 8 | Last popped byte |
| rx_count | output | 5 | Bytes stored |
| full_flag | output | 1 | Count reached the trigger |
| ready_flag | output | 1 | Partial queue has gone idle |
| ovr_flag | output | 1 | Overrun, sticky |
| rx_irq | output | 1 | Receive interrupt request |
| err_irq | output | 1 | Receive-error interrupt request |
| dma_req | output | 1 | One-cycle DMA request |

## Verification
The bench fills the queue to 16 and pushes once more. A design with an off-by-one full test would store a 17th byte or report overrun one byte too early. It then pops and pushes while the overrun flag is still set. A design without the lockout would accept that byte, and a design that cleared overrun on a pop would reopen reception. The idle test places a byte just before a tick and counts ticks: setting the idle flag at the first or second tick shows a one-frame window. The conditional write-clear cases write zeros while each condition still holds and again after it has lapsed, which catches a flag that clears unconditionally or never clears.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int unsigned FLAG_READY = 0;
  localparam int unsigned FLAG_FULL  = 1;
  localparam int unsigned FLAG_OVR   = 2;

  // Trigger level for a code, scaled from the queue depth.
  function automatic int unsigned trig_for(input int unsigned code, input int unsigned depth);
    case (code)
      0:       trig_for = 1;
      1:       trig_for = depth / 4;
      2:       trig_for = depth / 2;
      default: trig_for = depth - 2;
    endcase
  endfunction
endpackage

// File: rtl/rxq_trig_sel.sv
module rxq_trig_sel #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic [1:0]    sel,
  output logic [CW-1:0] lvl
);
  localparam int unsigned NCODES = 4;

  logic [CW-1:0] lvl_tab [NCODES];

  for (genvar g = 0; g < NCODES; g++) begin : g_lvl
    assign lvl_tab[g] = CW'(rxq_pkg::trig_for(g, DEPTH));
  end

  assign lvl = lvl_tab[sel];
endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [CW-1:0] count,
  output logic [CW-1:0] count_nxt,
  output logic [DW-1:0] head_data
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q, wr_d, rd_d;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    bump = (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_d      = wr_q;
    rd_d      = rd_q;
    count_nxt = count;
    if (clr) begin
      wr_d      = '0;
      rd_d      = '0;
      count_nxt = '0;
    end else begin
      if (push) wr_d = bump(wr_q);
      if (pop)  rd_d = bump(rd_q);
      case ({push, pop})
        2'b10:   count_nxt = count + 1'b1;
        2'b01:   count_nxt = count - 1'b1;
        default: count_nxt = count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      count <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      count <= count_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !clr) mem[wr_q] <= push_data;
  end

  assign head_data = mem[rd_q];
endmodule

// File: rtl/rxq_idle_watch.sv
module rxq_idle_watch (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic push,
  output logic quiet
);
  logic cur_q, prev_q, cur_d, prev_d;

  always_comb begin
    cur_d  = cur_q | push;
    prev_d = prev_q;
    if (tick) begin
      cur_d  = 1'b0;
      prev_d = cur_q | push;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      cur_q  <= cur_d;
      prev_q <= prev_d;
    end
  end

  // No byte in the interval ending now nor in the one before it.
  assign quiet = !(cur_q | push) && !prev_q;
endmodule

// File: rtl/rxq_flag_ctrl.sv
module rxq_flag_ctrl #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_en,
  input  logic          loop_sel,
  input  logic          line_valid,
  input  logic [DW-1:0] line_data,
  input  logic          loop_valid,
  input  logic [DW-1:0] loop_data,
  input  logic [1:0]    trig_sel,
  input  logic          rie,
  input  logic          eie,
  input  logic          frame_tick,
  input  logic          pop_req,
  input  logic          fifo_reset,
  input  logic          flag_wr,
  input  logic [2:0]    flag_wdata,
  output logic [DW-1:0] pop_data,
  output logic [CW-1:0] rx_count,
  output logic          full_flag,
  output logic          ready_flag,
  output logic          ovr_flag,
  output logic          rx_irq,
  output logic          err_irq,
  output logic          dma_req
);
  import rxq_pkg::*;

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  // Reset: asserted at once, released on a clock edge.
  logic [1:0] rs_q;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s_n = rs_q[1];

  logic          src_valid, rx_open, push_try, push_acc, pop_acc, has_space, ovr_evt;
  logic [DW-1:0] src_data, head_data;
  logic [CW-1:0] count_nxt, trig_lvl;
  logic          quiet, full_set, ready_set;
  logic          clr_full_req, clr_ready_req, clr_ovr_req, err_en;
  logic          full_d, ready_d, ovr_d, rx_irq_d, err_irq_d, dma_d;
  logic [DW-1:0] pop_d;

  assign src_valid = loop_sel ? loop_valid : line_valid;
  assign src_data  = loop_sel ? loop_data  : line_data;
  assign rx_open   = rx_en && !ovr_flag;
  assign pop_acc   = pop_req && (rx_count != '0) && !fifo_reset;
  assign has_space = (rx_count != FULL_CNT) || pop_acc;
  assign push_try  = src_valid && rx_open && !fifo_reset;
  assign push_acc  = push_try && has_space;
  assign ovr_evt   = push_try && !has_space;

  rxq_store #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) store_i (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .clr       (fifo_reset),
    .push      (push_acc),
    .push_data (src_data),
    .pop       (pop_acc),
    .count     (rx_count),
    .count_nxt (count_nxt),
    .head_data (head_data)
  );

  rxq_trig_sel #(.DEPTH(DEPTH), .CW(CW)) trig_i (
    .sel (trig_sel),
    .lvl (trig_lvl)
  );

  rxq_idle_watch idle_i (
    .clk   (clk),
    .rst_n (rst_s_n),
    .tick  (frame_tick),
    .push  (push_acc),
    .quiet (quiet)
  );

  assign full_set  = push_acc && (count_nxt >= trig_lvl);
  assign ready_set = frame_tick && !ready_flag && quiet &&
                     (count_nxt != '0) && (count_nxt < trig_lvl);

  assign clr_full_req  = flag_wr && !flag_wdata[FLAG_FULL];
  assign clr_ready_req = flag_wr && !flag_wdata[FLAG_READY];
  assign clr_ovr_req   = flag_wr && !flag_wdata[FLAG_OVR];
  assign err_en        = rie || eie;

  always_comb begin
    full_d = full_flag;
    if (fifo_reset)                                            full_d = 1'b0;
    else if (full_set)                                         full_d = 1'b1;
    else if ((pop_acc || clr_full_req) && count_nxt < trig_lvl) full_d = 1'b0;

    ready_d = ready_flag;
    if (fifo_reset)                                              ready_d = 1'b0;
    else if (ready_set)                                          ready_d = 1'b1;
    else if ((pop_acc || clr_ready_req) && count_nxt == '0)      ready_d = 1'b0;

    ovr_d = ovr_flag;
    if (ovr_evt)          ovr_d = 1'b1;
    else if (clr_ovr_req) ovr_d = 1'b0;

    rx_irq_d = rx_irq;
    if (rie && (full_set || ready_set))     rx_irq_d = 1'b1;
    else if (!rie || (!full_d && !ready_d)) rx_irq_d = 1'b0;

    err_irq_d = err_irq;
    if (ovr_evt && err_en)       err_irq_d = 1'b1;
    else if (!err_en || !ovr_d)  err_irq_d = 1'b0;

    dma_d = full_set || ready_set;

    pop_d = pop_data;
    if (pop_acc)      pop_d = head_data;
    else if (pop_req) pop_d = '0;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      full_flag  <= 1'b0;
      ready_flag <= 1'b0;
      ovr_flag   <= 1'b0;
      rx_irq     <= 1'b0;
      err_irq    <= 1'b0;
      dma_req    <= 1'b0;
      pop_data   <= '0;
    end else begin
      full_flag  <= full_d;
      ready_flag <= ready_d;
      ovr_flag   <= ovr_d;
      rx_irq     <= rx_irq_d;
      err_irq    <= err_irq_d;
      dma_req    <= dma_d;
      pop_data   <= pop_d;
    end
  end
endmodule

// File: rtl/rxq_flag_chk.sv
module rxq_flag_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] rx_count,
  input logic [CW-1:0] trig_lvl,
  input logic          full_flag,
  input logic          ready_flag,
  input logic          ovr_flag,
  input logic          dma_req,
  input logic          fifo_reset,
  input logic          pop_req,
  input logic          flag_wr,
  input logic [2:0]    flag_wdata,
  input logic [DW-1:0] pop_data
);
  assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= CW'(DEPTH));

  assert_full_dma_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full_flag) |-> dma_req);

  assert_ovr_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_flag && !(flag_wr && !flag_wdata[2])) |=> ovr_flag);

  assert_ovr_lockout_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_flag |=> (rx_count <= $past(rx_count)));

  assert_reset_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_reset |=> (rx_count == '0 && !full_flag && !ready_flag));

  assert_full_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(full_flag) |-> ($past(fifo_reset) || rx_count < $past(trig_lvl)));

  assert_ready_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready_flag) |-> ($past(fifo_reset) || rx_count == '0));

  assert_empty_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && rx_count == '0 && !fifo_reset) |=> (pop_data == '0));
endmodule

bind rxq_flag_ctrl rxq_flag_chk #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) chk_i (
  .clk        (clk),
  .rst_n      (rst_s_n),
  .rx_count   (rx_count),
  .trig_lvl   (trig_lvl),
  .full_flag  (full_flag),
  .ready_flag (ready_flag),
  .ovr_flag   (ovr_flag),
  .dma_req    (dma_req),
  .fifo_reset (fifo_reset),
  .pop_req    (pop_req),
  .flag_wr    (flag_wr),
  .flag_wdata (flag_wdata),
  .pop_data   (pop_data)
);

// File: tb/rxq_flag_ctrl_tb_top.sv
`timescale 1ns/1ps
module rxq_flag_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_en, loop_sel, line_valid, loop_valid;
  logic [7:0] line_data, loop_data;
  logic [1:0] trig_sel;
  logic       rie, eie, frame_tick, pop_req, fifo_reset, flag_wr;
  logic [2:0] flag_wdata;
  logic [7:0] pop_data;
  logic [4:0] rx_count;
  logic       full_flag, ready_flag, ovr_flag, rx_irq, err_irq, dma_req;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  rxq_flag_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .loop_sel(loop_sel),
    .line_valid(line_valid), .line_data(line_data),
    .loop_valid(loop_valid), .loop_data(loop_data),
    .trig_sel(trig_sel), .rie(rie), .eie(eie), .frame_tick(frame_tick),
    .pop_req(pop_req), .fifo_reset(fifo_reset), .flag_wr(flag_wr),
    .flag_wdata(flag_wdata), .pop_data(pop_data), .rx_count(rx_count),
    .full_flag(full_flag), .ready_flag(ready_flag), .ovr_flag(ovr_flag),
    .rx_irq(rx_irq), .err_irq(err_irq), .dma_req(dma_req)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Inputs set before cyc() are taken at the next rising edge; outputs are read 1 ns later.
  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic push_line(input logic [7:0] d);
    line_valid = 1'b1; line_data = d; cyc(); line_valid = 1'b0;
  endtask

  task automatic pop_one();
    pop_req = 1'b1; cyc(); pop_req = 1'b0;
  endtask

  task automatic tick();
    frame_tick = 1'b1; cyc(); frame_tick = 1'b0;
  endtask

  task automatic wr_flags(input logic [2:0] v);
    flag_wr = 1'b1; flag_wdata = v; cyc(); flag_wr = 1'b0;
  endtask

  task automatic flush();
    fifo_reset = 1'b1; cyc(); fifo_reset = 1'b0;
  endtask

  task automatic t_reset_state();
    check("R1", "count after reset", rx_count, 0);
    check("R2", "full after reset", full_flag, 0);
    check("R5", "ready after reset", ready_flag, 0);
    check("R3", "ovr after reset", ovr_flag, 0);
    check("R2", "irq/dma after reset", {rx_irq, err_irq, dma_req}, 0);
  endtask

  task automatic t_trigger_one();
    trig_sel = 2'd0; rie = 1'b1;
    push_line(8'hA5);
    check("R1", "count after push", rx_count, 1);
    check("R2", "full at level 1", full_flag, 1);
    check("R2", "rx_irq at level 1", rx_irq, 1);
    check("R2", "dma pulse", dma_req, 1);
    cyc();
    check("R2", "dma one cycle", dma_req, 0);
    pop_one();
    check("R11", "popped byte", pop_data, 8'hA5);
    check("R6", "full cleared by pop", full_flag, 0);
    check("R6", "rx_irq dropped", rx_irq, 0);
    check("R1", "count after pop", rx_count, 0);
  endtask

  task automatic t_trigger_four();
    trig_sel = 2'd1;
    for (int i = 0; i < 3; i++) push_line(8'h10 + 8'(i));
    check("R2", "below level 4", full_flag, 0);
    push_line(8'h13);
    check("R2", "at level 4", full_flag, 1);
    wr_flags(3'b101);
    check("R8", "full kept while count>=trig", full_flag, 1);
    pop_one();
    check("R6", "full cleared at 3 of 4", full_flag, 0);
    check("R6", "ready stays clear", ready_flag, 0);
    check("R1", "first out", pop_data, 8'h10);
    flush();
  endtask

  task automatic t_overrun();
    trig_sel = 2'd3; rie = 1'b0; eie = 1'b1;
    for (int i = 0; i < 16; i++) push_line(8'h40 + 8'(i));
    check("R1", "count at 16", rx_count, 16);
    check("R2", "full at level 14", full_flag, 1);
    check("R3", "no overrun yet", ovr_flag, 0);
    push_line(8'hEE);
    check("R3", "overrun set", ovr_flag, 1);
    check("R3", "err_irq raised", err_irq, 1);
    check("R3", "count stays 16", rx_count, 16);
    pop_one();
    check("R1", "oldest after overrun", pop_data, 8'h40);
    push_line(8'h77);
    check("R4", "locked out", rx_count, 15);
    check("R4", "overrun sticky", ovr_flag, 1);
    wr_flags(3'b011);
    check("R4", "overrun cleared", ovr_flag, 0);
    check("R4", "err_irq dropped", err_irq, 0);
    push_line(8'h88);
    check("R4", "reopened", rx_count, 16);
    for (int i = 1; i < 16; i++) begin
      pop_one();
      check("R1", "order", pop_data, 32'h40 + i);
    end
    pop_one();
    check("R1", "last byte", pop_data, 8'h88);
    check("R1", "drained", rx_count, 0);
    eie = 1'b0;
  endtask

  task automatic t_idle();
    trig_sel = 2'd2; rie = 1'b1;
    flush();
    push_line(8'h5C);
    tick();
    check("R5", "not set at first tick", ready_flag, 0);
    tick();
    check("R5", "not set at second tick", ready_flag, 0);
    tick();
    check("R5", "set at third tick", ready_flag, 1);
    check("R5", "rx_irq on idle", rx_irq, 1);
    check("R5", "dma on idle", dma_req, 1);
    wr_flags(3'b110);
    check("R8", "ready kept while non-empty", ready_flag, 1);
    pop_one();
    check("R6", "ready cleared on empty", ready_flag, 0);
    check("R6", "rx_irq dropped", rx_irq, 0);
  endtask

  task automatic t_write_clear_lapsed();
    trig_sel = 2'd0;
    push_line(8'h21);
    check("R2", "full set", full_flag, 1);
    trig_sel = 2'd3;
    wr_flags(3'b101);
    check("R8", "full cleared once below trig", full_flag, 0);
    flush();
  endtask

  task automatic t_fifo_reset();
    trig_sel = 2'd1; rie = 1'b1;
    for (int i = 0; i < 4; i++) push_line(8'h30);
    check("R2", "full before reset", full_flag, 1);
    flush();
    check("R7", "count zero", rx_count, 0);
    check("R7", "flags clear", {full_flag, ready_flag}, 0);
    check("R7", "rx_irq dropped", rx_irq, 0);
  endtask

  task automatic t_source();
    rx_en = 1'b0;
    push_line(8'h99);
    check("R4", "rx_en low ignores", rx_count, 0);
    rx_en = 1'b1; loop_sel = 1'b1;
    push_line(8'h11);
    check("R9", "line ignored in loopback", rx_count, 0);
    loop_valid = 1'b1; loop_data = 8'h22; cyc(); loop_valid = 1'b0;
    check("R9", "loop byte taken", rx_count, 1);
    pop_one();
    check("R9", "loop byte value", pop_data, 8'h22);
    loop_sel = 1'b0;
  endtask

  task automatic t_empty_pop();
    pop_one();
    check("R10", "empty pop data", pop_data, 0);
    check("R10", "empty pop count", rx_count, 0);
    check("R10", "empty pop flags", {full_flag, ready_flag, ovr_flag}, 0);
  endtask

  initial begin
    rst_n = 1'b0; rx_en = 1'b1; loop_sel = 1'b0;
    line_valid = 1'b0; line_data = '0; loop_valid = 1'b0; loop_data = '0;
    trig_sel = '0; rie = 1'b0; eie = 1'b0; frame_tick = 1'b0;
    pop_req = 1'b0; fifo_reset = 1'b0; flag_wr = 1'b0; flag_wdata = 3'b111;
    repeat (3) cyc();
    rst_n = 1'b1;
    repeat (4) cyc();
    t_reset_state();
    t_trigger_one();
    t_trigger_four();
    t_overrun();
    t_idle();
    t_write_clear_lapsed();
    t_fifo_reset();
    t_source();
    t_empty_pop();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule